// File: doc/BRIEF.md
# Stereo Gain Ramp and Soft-Mute Controller

This block works out the gain that a left/right audio path should apply. It does not scale the samples itself. Each channel takes a 4-bit coarse code, and the codes run from -12 dB at code 0 to +10.5 dB at code 15 in 1.5 dB increments. The applied gain never jumps to a new code. It glides there in small fine increments of about 0.13 dB or 0.26 dB, and a programmable number of sample periods separates each increment. This avoids audible clicks when the volume changes. Soft mute uses the same glide and moves both channels down to a floor below the lowest coarse setting. Releasing mute ramps both channels back up to their codes.

Gain is reported as a signed count of 0.125 dB units (nominally 0.13 dB) measured from -12 dB. One coarse code is 12 units, which is 1.5 dB divided by the small step and rounded. With the large step size each increment moves 2 units. A single interval timer is shared by both channels. It runs only while some channel is away from its target, and it counts sample strobes.

Top module: `gain_ramp_ctrl`

## Requirements
- R1: While reset is held and right after it is released, both gain outputs read 96 (code 8, 0 dB). With codes of 8 and mute off, `busy` is low.
- R2: With mute off, each channel settles at a gain of exactly 12 × its coarse code (0 for code 0, 180 for code 15).
- R3: Each increment moves a gain by 1 unit when `big_step` is 0 and by 2 units when it is 1. The last increment is shortened so that the gain lands on the target and never passes it.
- R4: An increment happens on the N-th sample strobe counted while busy, and the count restarts after every increment. N is BASE × {2,3,4,5,6,8,12,16} for `interval_sel` values 0 through 7, which gives 64 to 512 strobes at the default BASE of 32. The strobe count is cleared while the block is idle.
- R5: While `mute_en` is high, both channels ramp to the floor value −48 (−18 dB) using the normal increments. When mute is released, each channel ramps back to 12 × its code.
- R6: If a target changes during a ramp, the gain keeps moving from its present value toward the new target, with no jump and no restart.
- R7: Each channel moves only toward its own target. The two channels step on the same timer events.
- R8: `busy` is high exactly when either channel's gain differs from its present target.
- R9: A gain changes only on a strobe that completes an interval. In every other cycle it holds its value.

Ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sample_stb | input | 1 | One pulse per audio sample period |
| code_l | input | 4 | Left coarse gain code |
| code_r | input | 4 | Right coarse gain code |
| mute_en | input | 1 | Soft mute request |
| big_step | input | 1 | 0: 1-unit increments, 1: 2-unit increments |
| interval_sel | input | 3 | Selects the number of strobes between increments |
| gain_l | output | 9 | Left applied gain, signed units of 0.125 dB above -12 dB |
| gain_r | output | 9 | Right applied gain, same encoding |
| busy | output | 1 | A channel is still ramping |

## Verification
The hardest states to reach are a gain that has gone odd and must finish under the 2-unit step, and a retarget that arrives partway through a ramp. To get there, the bench starts a ramp with 1-unit steps, switches to 2-unit steps after one increment, and moves the code in the middle of a long glide. It uses a small BASE so that the wait for each increment stays short. A companion test raises the strobe spacing so that long stretches pass with no qualifying strobe, which shows that the gain holds between increments.

// File: rtl/gain_ramp_pkg.sv
package gain_ramp_pkg;

   localparam int unsigned IVL_SEL_W = 3;

   // Multiplier applied to the base interval for each interval select code
   function automatic int unsigned ivl_mult(input logic [IVL_SEL_W-1:0] sel);
      case (sel)
         3'd0:    return 2;
         3'd1:    return 3;
         3'd2:    return 4;
         3'd3:    return 5;
         3'd4:    return 6;
         3'd5:    return 8;
         3'd6:    return 12;
         default: return 16;
      endcase
   endfunction

endpackage

// File: rtl/gain_step_timer.sv
module gain_step_timer
   import gain_ramp_pkg::*;
#(
   parameter int unsigned BASE_INTERVAL = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sample_stb,
   input  logic                 active,
   input  logic [IVL_SEL_W-1:0] interval_sel,
   output logic                 step_en
);
   localparam int unsigned MAX_LEN = BASE_INTERVAL * 16;
   localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] len;
   logic [CNT_W:0]   cnt_inc;
   logic             expire;

   always_comb begin
      len     = CNT_W'(BASE_INTERVAL * ivl_mult(interval_sel));
      cnt_inc = {1'b0, cnt_q} + (CNT_W+1)'(1);
   end

   // >= so that shortening the interval mid-count fires at once
   assign expire  = cnt_inc >= {1'b0, len};
   assign step_en = active & sample_stb & expire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (!active)    cnt_q <= '0;
      else if (sample_stb) cnt_q <= expire ? '0 : cnt_inc[CNT_W-1:0];
   end

   a_r4_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> cnt_q == '0);
   a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CNT_W'(MAX_LEN));
   a_r4_hold_no_stb: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !sample_stb) |=> $stable(cnt_q));

endmodule

// File: rtl/gain_ramp_lane.sv
module gain_ramp_lane #(
   parameter int CODE_W        = 4,
   parameter int GAIN_W        = 9,
   parameter int FINE_PER_CODE = 12,
   parameter int MUTE_FLOOR    = -48,
   parameter int RESET_GAIN    = 96
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     step_en,
   input  logic                     big_step,
   input  logic                     mute_en,
   input  logic [CODE_W-1:0]        code,
   output logic signed [GAIN_W-1:0] gain_q,
   output logic                     at_target
);
   logic signed [GAIN_W-1:0] target;
   logic signed [GAIN_W:0]   gain_x;
   logic signed [GAIN_W:0]   diff;
   logic signed [GAIN_W:0]   mag;
   logic signed [GAIN_W:0]   mv;
   logic signed [GAIN_W:0]   nxt;

   always_comb begin
      target = mute_en ? GAIN_W'(MUTE_FLOOR) : GAIN_W'(FINE_PER_CODE * int'(code));
      gain_x = $signed({gain_q[GAIN_W-1], gain_q});
      diff   = $signed({target[GAIN_W-1], target}) - gain_x;
      mag    = diff[GAIN_W] ? -diff : diff;
      mv     = big_step ? (GAIN_W+1)'(2) : (GAIN_W+1)'(1);
      if (mag < mv) mv = mag;
      nxt    = diff[GAIN_W] ? gain_x - mv : gain_x + mv;
   end

   assign at_target = (diff == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      gain_q <= GAIN_W'(RESET_GAIN);
      else if (step_en && !at_target)  gain_q <= nxt[GAIN_W-1:0];
   end

   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !step_en |=> $stable(gain_q));
   a_r3_step_size: assert property (@(posedge clk) disable iff (!rst_n)
      step_en |=> ((gain_q - $past(gain_q)) <= 2) && ((gain_q - $past(gain_q)) >= -2));
   a_r3_no_overshoot_up: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && diff > 0) |=> (gain_q > $past(gain_q)) && (gain_q <= $past(target)));
   a_r3_no_overshoot_dn: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && diff < 0) |=> (gain_q < $past(gain_q)) && (gain_q >= $past(target)));

endmodule

// File: rtl/gain_ramp_ctrl.sv
module gain_ramp_ctrl
   import gain_ramp_pkg::*;
#(
   parameter int          CODE_W        = 4,
   parameter int          GAIN_W        = 9,
   parameter int          FINE_PER_CODE = 12,
   parameter int          MUTE_FLOOR    = -48,
   parameter int          RESET_CODE    = 8,
   parameter int unsigned BASE_INTERVAL = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sample_stb,
   input  logic [CODE_W-1:0]        code_l,
   input  logic [CODE_W-1:0]        code_r,
   input  logic                     mute_en,
   input  logic                     big_step,
   input  logic [IVL_SEL_W-1:0]     interval_sel,
   output logic signed [GAIN_W-1:0] gain_l,
   output logic signed [GAIN_W-1:0] gain_r,
   output logic                     busy
);
   localparam int NUM_CH     = 2;
   localparam int MAX_TARGET = (2**CODE_W - 1) * FINE_PER_CODE;
   localparam int RESET_GAIN = RESET_CODE * FINE_PER_CODE;

   if (MAX_TARGET >= 2**(GAIN_W-1)) begin : g_bad_width
      $error("GAIN_W too narrow for the highest coarse target");
   end
   if (MUTE_FLOOR >= 0 || MUTE_FLOOR < -(2**(GAIN_W-1))) begin : g_bad_floor
      $error("MUTE_FLOOR must be negative and fit in GAIN_W");
   end
   if (RESET_CODE >= 2**CODE_W || BASE_INTERVAL < 1) begin : g_bad_cfg
      $error("RESET_CODE or BASE_INTERVAL out of range");
   end

   logic [CODE_W-1:0]        code_a [NUM_CH];
   logic signed [GAIN_W-1:0] gain_a [NUM_CH];
   logic [NUM_CH-1:0]        settled;
   logic                     step_en;

   assign code_a[0] = code_l;
   assign code_a[1] = code_r;

   assign busy = ~&settled;

   gain_step_timer #(
      .BASE_INTERVAL (BASE_INTERVAL)
   ) u_timer (
      .clk          (clk),
      .rst_n        (rst_n),
      .sample_stb   (sample_stb),
      .active       (busy),
      .interval_sel (interval_sel),
      .step_en      (step_en)
   );

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
      gain_ramp_lane #(
         .CODE_W        (CODE_W),
         .GAIN_W        (GAIN_W),
         .FINE_PER_CODE (FINE_PER_CODE),
         .MUTE_FLOOR    (MUTE_FLOOR),
         .RESET_GAIN    (RESET_GAIN)
      ) u_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .step_en   (step_en),
         .big_step  (big_step),
         .mute_en   (mute_en),
         .code      (code_a[ch]),
         .gain_q    (gain_a[ch]),
         .at_target (settled[ch])
      );
   end

   assign gain_l = gain_a[0];
   assign gain_r = gain_a[1];

   a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(gain_l) && $stable(gain_r));
   a_r5_floor: assert property (@(posedge clk) disable iff (!rst_n)
      (gain_l >= MUTE_FLOOR) && (gain_r >= MUTE_FLOOR));
   a_r2_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
      (gain_l <= MAX_TARGET) && (gain_r <= MAX_TARGET));

endmodule

// File: tb/gain_ramp_ctrl_test.sv
module gain_ramp_ctrl_test;
   localparam int BASE  = 2;
   localparam int FPC   = 12;
   localparam int FLOOR = -48;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sample_stb = 1'b0;
   logic       mute_en = 1'b0;
   logic       big_step = 1'b1;
   logic [3:0] code_l = 4'd8;
   logic [3:0] code_r = 4'd8;
   logic [2:0] interval_sel = 3'd0;
   logic signed [8:0] gain_l, gain_r;
   logic       busy;

   int checks = 0, errors = 0;
   int m_gl = 96, m_gr = 96, m_cnt = 0;
   int stb_div = 1, cyc = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   gain_ramp_ctrl #(.BASE_INTERVAL(BASE)) uut (
      .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb),
      .code_l(code_l), .code_r(code_r), .mute_en(mute_en),
      .big_step(big_step), .interval_sel(interval_sel),
      .gain_l(gain_l), .gain_r(gain_r), .busy(busy)
   );

   function automatic int ivl_len(input int sel);
      int m;
      case (sel)
         0: m = 2;  1: m = 3;  2: m = 4;  3: m = 5;
         4: m = 6;  5: m = 8;  6: m = 12; default: m = 16;
      endcase
      return BASE * m;
   endfunction

   function automatic int tgt(input int code, input bit mute);
      return mute ? FLOOR : code * FPC;
   endfunction

   function automatic int move(input int g, input int t, input bit big);
      int s, d;
      s = big ? 2 : 1;
      d = t - g;
      if (d > 0) return g + ((d < s) ? d : s);
      if (d < 0) return g - ((-d < s) ? -d : s);
      return g;
   endfunction

   function automatic bit model_busy();
      return (m_gl != tgt(int'(code_l), mute_en)) || (m_gr != tgt(int'(code_r), mute_en));
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // one clock: inputs already stable, model advances with the DUT
   task automatic step1();
      int nl, nr;
      sample_stb = ((cyc % stb_div) == 0);
      cyc++;
      if (!model_busy()) m_cnt = 0;
      else if (sample_stb) begin
         if (m_cnt + 1 >= ivl_len(int'(interval_sel))) begin
            nl = move(m_gl, tgt(int'(code_l), mute_en), big_step);
            nr = move(m_gr, tgt(int'(code_r), mute_en), big_step);
            m_gl = nl; m_gr = nr; m_cnt = 0;
         end else m_cnt++;
      end
      @(posedge clk);
      @(negedge clk);
      check(int'(gain_l) == m_gl, "R9 left gain track", int'(gain_l), m_gl);
      check(int'(gain_r) == m_gr, "R9 right gain track", int'(gain_r), m_gr);
      check(busy == model_busy(), "R8 busy flag", int'(busy), int'(model_busy()));
   endtask

   task automatic settle();
      for (int i = 0; i < 20000; i++) begin
         if (!model_busy()) break;
         step1();
      end
      step1();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(int'(gain_l) == 96, "R1 left in reset", int'(gain_l), 96);
      check(int'(gain_r) == 96, "R1 right in reset", int'(gain_r), 96);
      rst_n = 1'b1;
      check(int'(gain_l) == 96, "R1 left after reset", int'(gain_l), 96);
      check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
      repeat (5) step1();

      // R2 / R7 sweep over every code with varied step, interval and strobe spacing
      for (int c = 0; c < 16; c++) begin
         code_l = 4'(c); code_r = 4'(15 - c);
         big_step = c[0]; interval_sel = 3'(c % 8); stb_div = 1 + (c % 3);
         settle();
         check(int'(gain_l) == c * FPC, "R2 left settled", int'(gain_l), c * FPC);
         check(int'(gain_r) == (15 - c) * FPC, "R7 right settled", int'(gain_r), (15 - c) * FPC);
         check(busy == 1'b0, "R8 idle after settle", int'(busy), 0);
      end

      // R4 latency of the first increment for every interval select
      stb_div = 1;
      for (int k = 0; k < 8; k++) begin
         code_l = 4'd4; code_r = 4'd4; settle();
         big_step = 1'b1; interval_sel = 3'(k); code_l = 4'd5;
         begin
            int n, old;
            n = 0; old = int'(gain_l);
            while (int'(gain_l) == old && n < 200) begin step1(); n++; end
            check(n == ivl_len(k), "R4 strobes to first step", n, ivl_len(k));
         end
         settle();
      end

      // R9 no qualifying strobe for a long stretch: gain holds
      code_l = 4'd2; settle();
      stb_div = 1000; cyc = 1; code_l = 4'd10; interval_sel = 3'd0;
      repeat (60) step1();
      check(int'(gain_l) == 24, "R9 hold without strobe", int'(gain_l), 24);
      stb_div = 1; settle();

      // R5 soft mute down and release
      code_l = 4'd15; code_r = 4'd3; big_step = 1'b1; interval_sel = 3'd1; settle();
      mute_en = 1'b1;
      repeat (12) step1();
      check(int'(gain_l) == 176, "R5 mute is gradual", int'(gain_l), 176);
      settle();
      check(int'(gain_l) == FLOOR, "R5 left at floor", int'(gain_l), FLOOR);
      check(int'(gain_r) == FLOOR, "R5 right at floor", int'(gain_r), FLOOR);
      mute_en = 1'b0; settle();
      check(int'(gain_l) == 180, "R5 left restored", int'(gain_l), 180);
      check(int'(gain_r) == 36, "R5 right restored", int'(gain_r), 36);

      // R6 retarget in the middle of a ramp
      code_l = 4'd0; code_r = 4'd0; settle();
      big_step = 1'b0; interval_sel = 3'd0; code_l = 4'd15;
      repeat (40) step1();
      check(int'(gain_l) == 10, "R6 mid ramp", int'(gain_l), 10);
      code_l = 4'd1;
      repeat (4) step1();
      check(int'(gain_l) == 11, "R6 continues from present", int'(gain_l), 11);
      settle();
      check(int'(gain_l) == 12, "R6 new target reached", int'(gain_l), 12);

      // R3 odd gain finished with the large step, clamped at target
      code_l = 4'd8; code_r = 4'd8; big_step = 1'b1; settle();
      big_step = 1'b0; code_l = 4'd9;
      repeat (4) step1();
      check(int'(gain_l) == 97, "R3 unit step", int'(gain_l), 97);
      big_step = 1'b1;
      repeat (4) step1();
      check(int'(gain_l) == 99, "R3 double step", int'(gain_l), 99);
      begin
         int mx;
         mx = int'(gain_l);
         for (int i = 0; i < 200 && model_busy(); i++) begin
            step1();
            if (int'(gain_l) > mx) mx = int'(gain_l);
         end
         check(mx == 108, "R3 no overshoot", mx, 108);
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule